// File: doc/BRIEF.md
# CSMA/CD Serial Frame Transmitter

This block sits between a host that supplies frame content as 16-bit words and a 10 Mb/s transceiver that expects one bit per transmit clock. The host first writes a length word giving the number of content octets (addresses, type/length field and payload). It then streams the content words through a one-word buffer paced by a busy flag. The block defers while the medium carries a signal and waits out the interframe gap. It then emits the preamble and delimiter, the content padded to the minimum size, and a 32-bit check sequence.

When the collision input is seen during a transmission, the block sends a jam run and then drops transmit enable. It pulses a halt output and backs off for a random whole number of slots. After the backoff it accepts the same frame again from the host, starting from the length word. Content is not kept inside the block. When the final permitted attempt also collides, the block pulses an abort output instead and returns to idle.

Top module: `csma_tx`

## Requirements
- R1: Out of reset, tx_en, halt and abort are low and host_busy is low.
- R2: A write with host_frame low opens a frame, and only while the block is idle. Content words (host_frame high) are taken only while host_busy is low. Writes made while host_busy is high leave the transmitted stream unchanged.
- R3: Every transmission opens with 64 bits: seven 0x55 octets and one 0xD5 octet, each sent bit 0 first, so the line reads 1,0 repeated and ends 1,1.
- R4: Each content word goes out low byte first, and each byte bit 0 first. For an odd length, only the low byte of the last word is sent.
- R5: Content shorter than MIN_OCTETS (60) octets is followed by zero octets up to 60.
- R6: After the padded content come 32 check bits. They are the one's complement of a CRC with polynomial 0x04C11DB7 and preset all ones, processed bit 0 first (reflected), computed over content and padding and sent bit 0 first.
- R7: No transmission starts while carrier is high. With a frame pending, tx_en rises exactly IFG_BITS+1 cycles after the last cycle with carrier high.
- R8: A collision sampled while sending preamble, content or check bits is followed by exactly JAM_BITS cycles of tx_data high with tx_en high, after which tx_en falls.
- R9: halt is a one-cycle pulse in the first cycle after the jam. The host then resupplies the frame from its length word, and the retransmission is complete and correct.
- R10: After the n-th collision of a frame, host_busy stays high for k*SLOT_BITS+1 cycles counted from the halt cycle, with 0 <= k < 2^min(n, BACKOFF_CAP).
- R11: The MAX_TRIES-th collision of one frame produces a one-cycle abort pulse instead of halt. It produces no backoff, and host_busy is low in the abort cycle.
- R12: tx_en stays high without a break from the first preamble bit to the last check bit: 64 + 8*max(L,60) + 32 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_data | input | 16 | Length word or content word |
| host_wr | input | 1 | Write strobe for host_data |
| host_frame | input | 1 | 1: content word, 0: length word (octets) |
| host_busy | output | 1 | 0 when a word may be written |
| halt | output | 1 | Pulse: frame collided, resupply from the length word |
| abort | output | 1 | Pulse: retry limit reached, frame dropped |
| carrier | input | 1 | Medium busy |
| collision | input | 1 | Collision detected on the medium |
| tx_data | output | 1 | Serial transmit bit |
| tx_en | output | 1 | Transmit enable |

## Verification
The end of a frame and a collision can land in the same cycle. This happens when the collision input arrives with the last check bit on the line, so the block must choose between finishing and jamming. The bench raises the collision in exactly that cycle. It expects the full 32 check bits to be followed at once by a complete jam run and a halt, and it then expects a correct retransmission. The same collision against the first preamble bit and in mid-content is run alongside it. A host write against the buffer-refill cycle is covered by random spurious writes while busy, which must leave the stream bit-exact.

// File: rtl/csma_tx_pkg.sv
package csma_tx_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_DEFER,
      ST_PRE,
      ST_DATA,
      ST_FCS,
      ST_JAM,
      ST_BACK
   } tx_state_t;

   localparam int          CRC_W        = 32;
   localparam logic [31:0] CRC_POLY_REV = 32'hEDB88320;
   localparam int          LFSR_W       = 16;
   localparam logic [15:0] LFSR_TAPS    = 16'hB400;
   localparam logic [15:0] LFSR_SEED    = 16'hACE1;
endpackage

// File: rtl/csma_tx_crc.sv
module csma_tx_crc
   import csma_tx_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic init,
   input  logic step,
   input  logic shift,
   input  logic din,
   output logic fcs_bit
);
   logic [CRC_W-1:0] crc_q;
   logic [CRC_W-1:0] crc_nx;
   logic             fb;

   assign fb = crc_q[0] ^ din;

   // reflected update, one bit per cycle
   for (genvar i = 0; i < CRC_W; i++) begin : g_bit
      if (i == CRC_W - 1) begin : g_top
         assign crc_nx[i] = fb & CRC_POLY_REV[i];
      end else begin : g_mid
         assign crc_nx[i] = crc_q[i+1] ^ (fb & CRC_POLY_REV[i]);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      crc_q <= '1;
      else if (init)   crc_q <= '1;
      else if (step)   crc_q <= crc_nx;
      else if (shift)  crc_q <= {1'b1, crc_q[CRC_W-1:1]};
   end

   assign fcs_bit = ~crc_q[0];
endmodule

// File: rtl/csma_tx_backoff.sv
module csma_tx_backoff
   import csma_tx_pkg::*;
#(
   parameter int CAP       = 10,
   parameter int SLOT_BITS = 512,
   localparam int EXP_W    = $clog2(CAP + 1),
   localparam int SLOT_W   = $clog2(SLOT_BITS)
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [EXP_W-1:0] exp_in,
   output logic             done
);
   localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(SLOT_BITS - 1);

   if (CAP < 1 || CAP > LFSR_W) begin : g_bad_cap
      $error("backoff cap out of range");
   end
   if (SLOT_BITS < 2) begin : g_bad_slot
      $error("slot must be at least two bits");
   end

   logic [LFSR_W-1:0] lfsr_q;
   logic [CAP-1:0]    fold;
   logic [CAP-1:0]    mask;
   logic [CAP-1:0]    slots_q;
   logic [SLOT_W-1:0] bitc_q;
   logic              active_q;

   for (genvar i = 0; i < CAP; i++) begin : g_mask
      assign mask[i] = (int'(exp_in) > i);
   end

   always_comb begin
      fold = '0;
      for (int j = 0; j < LFSR_W; j++) fold[j % CAP] = fold[j % CAP] ^ lfsr_q[j];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lfsr_q <= LFSR_SEED;
      else        lfsr_q <= lfsr_q[0] ? ((lfsr_q >> 1) ^ LFSR_TAPS) : (lfsr_q >> 1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         slots_q  <= '0;
         bitc_q   <= '0;
         active_q <= 1'b0;
      end else if (start) begin
         slots_q  <= fold & mask;
         bitc_q   <= '0;
         active_q <= 1'b1;
      end else if (active_q) begin
         if (slots_q == '0) begin
            active_q <= 1'b0;
         end else if (bitc_q == SLOT_LAST) begin
            bitc_q  <= '0;
            slots_q <= slots_q - 1'b1;
         end else begin
            bitc_q <= bitc_q + 1'b1;
         end
      end
   end

   assign done = active_q && (slots_q == '0);
endmodule

// File: rtl/csma_tx_wordbuf.sv
module csma_tx_wordbuf #(
   parameter int W = 16
)(
   input  logic         clk,
   input  logic         rst_n,
   input  logic         flush,
   input  logic         wr,
   input  logic [W-1:0] wdata,
   input  logic         take,
   output logic         full,
   output logic [W-1:0] rdata
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         full  <= 1'b0;
         rdata <= '0;
      end else if (flush) begin
         full <= 1'b0;
      end else if (wr) begin
         full  <= 1'b1;
         rdata <= wdata;
      end else if (take) begin
         full <= 1'b0;
      end
   end
endmodule

// File: rtl/csma_tx.sv
module csma_tx
   import csma_tx_pkg::*;
#(
   parameter int WORD_W      = 16,
   parameter int LEN_W       = 16,
   parameter int PRE_OCTETS  = 7,
   parameter int IFG_BITS    = 96,
   parameter int JAM_BITS    = 32,
   parameter int SLOT_BITS   = 512,
   parameter int BACKOFF_CAP = 10,
   parameter int MAX_TRIES   = 16,
   parameter int MIN_OCTETS  = 60
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [WORD_W-1:0] host_data,
   input  logic              host_wr,
   input  logic              host_frame,
   output logic              host_busy,
   output logic              halt,
   output logic              abort,
   input  logic              carrier,
   input  logic              collision,
   output logic              tx_data,
   output logic              tx_en
);
   localparam int BYTES    = WORD_W / 8;
   localparam int BSEL_W   = $clog2(BYTES);
   localparam int PRE_BITS = PRE_OCTETS * 8 + 8;
   localparam int M1       = (IFG_BITS > PRE_BITS) ? IFG_BITS : PRE_BITS;
   localparam int M2       = (JAM_BITS > CRC_W) ? JAM_BITS : CRC_W;
   localparam int CNT_MAX  = (M1 > M2) ? M1 : M2;
   localparam int CNT_W    = $clog2(CNT_MAX + 1);
   localparam int TRY_W    = $clog2(MAX_TRIES + 1);
   localparam int EXP_W    = $clog2(BACKOFF_CAP + 1);

   localparam logic [CNT_W-1:0] IFG_LAST = CNT_W'(IFG_BITS - 1);
   localparam logic [CNT_W-1:0] PRE_LAST = CNT_W'(PRE_BITS - 1);
   localparam logic [CNT_W-1:0] JAM_LAST = CNT_W'(JAM_BITS - 1);
   localparam logic [CNT_W-1:0] FCS_LAST = CNT_W'(CRC_W - 1);
   localparam logic [CNT_W-1:0] OCT_LAST = CNT_W'(7);
   localparam logic [LEN_W-1:0] MIN_LEN  = LEN_W'(MIN_OCTETS);

   if (WORD_W < 16 || (WORD_W % 8) != 0 || (BYTES & (BYTES - 1)) != 0) begin : g_bad_word
      $error("word width must be a power-of-two number of octets, at least two");
   end
   if (LEN_W > WORD_W || LEN_W < 8) begin : g_bad_len
      $error("length field must fit the word");
   end
   if (IFG_BITS < 1 || JAM_BITS < 1 || PRE_OCTETS < 1) begin : g_bad_time
      $error("gap, jam and preamble must be non-empty");
   end
   if (MAX_TRIES < 2) begin : g_bad_tries
      $error("at least two attempts needed");
   end

   tx_state_t         state;
   logic [CNT_W-1:0]  cnt;
   logic [LEN_W-1:0]  len_q, oct_q, words_left;
   logic [WORD_W-1:0] sh_q;
   logic [TRY_W-1:0]  tries_q, tries_next;
   logic              halt_q, abort_q;

   logic              buf_full, in_data, load_now, data_bit, fcs_bit;
   logic              accept_len, accept_word, collide, bo_start, bo_done, last_try;
   logic [WORD_W-1:0] buf_rd;
   logic [LEN_W:0]    len_ext;
   logic [LEN_W-1:0]  words_init, send_octs, oct_inc;
   logic [EXP_W-1:0]  bo_exp;

   assign len_ext    = {1'b0, host_data[LEN_W-1:0]} + (LEN_W+1)'(BYTES - 1);
   assign words_init = LEN_W'(len_ext >> BSEL_W);
   assign send_octs  = (len_q < MIN_LEN) ? MIN_LEN : len_q;
   assign oct_inc    = oct_q + 1'b1;
   assign in_data    = oct_q < len_q;
   assign load_now   = (state == ST_DATA) && (cnt == '0) && in_data && (oct_q[BSEL_W-1:0] == '0);
   assign data_bit   = in_data ? (load_now ? buf_rd[0] : sh_q[0]) : 1'b0;
   assign collide    = collision && (state inside {ST_PRE, ST_DATA, ST_FCS});
   assign tries_next = tries_q + 1'b1;
   assign last_try   = (tries_next == TRY_W'(MAX_TRIES));
   assign bo_start   = (state == ST_JAM) && (cnt == JAM_LAST) && !last_try;
   assign bo_exp     = (int'(tries_next) > BACKOFF_CAP) ? EXP_W'(BACKOFF_CAP) : EXP_W'(tries_next);

   always_comb begin
      case (state)
         ST_IDLE:                    host_busy = 1'b0;
         ST_DEFER, ST_PRE, ST_DATA:  host_busy = buf_full || (words_left == '0);
         default:                    host_busy = 1'b1;
      endcase
   end

   assign accept_len  = (state == ST_IDLE) && host_wr && !host_frame;
   assign accept_word = host_wr && host_frame && !host_busy && (state != ST_IDLE);

   always_comb begin
      case (state)
         ST_PRE:  tx_data = (cnt == PRE_LAST) | ~cnt[0];
         ST_DATA: tx_data = data_bit;
         ST_FCS:  tx_data = fcs_bit;
         ST_JAM:  tx_data = 1'b1;
         default: tx_data = 1'b0;
      endcase
   end
   assign tx_en = state inside {ST_PRE, ST_DATA, ST_FCS, ST_JAM};
   assign halt  = halt_q;
   assign abort = abort_q;

   csma_tx_wordbuf #(.W(WORD_W)) u_buf (
      .clk(clk), .rst_n(rst_n), .flush(collide), .wr(accept_word), .wdata(host_data),
      .take(load_now), .full(buf_full), .rdata(buf_rd)
   );

   csma_tx_crc u_crc (
      .clk(clk), .rst_n(rst_n), .init(state == ST_PRE), .step(state == ST_DATA),
      .shift(state == ST_FCS), .din(data_bit), .fcs_bit(fcs_bit)
   );

   csma_tx_backoff #(.CAP(BACKOFF_CAP), .SLOT_BITS(SLOT_BITS)) u_bo (
      .clk(clk), .rst_n(rst_n), .start(bo_start), .exp_in(bo_exp), .done(bo_done)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= ST_IDLE;
         cnt        <= '0;
         len_q      <= '0;
         oct_q      <= '0;
         words_left <= '0;
         sh_q       <= '0;
         tries_q    <= '0;
         halt_q     <= 1'b0;
         abort_q    <= 1'b0;
      end else begin
         halt_q  <= 1'b0;
         abort_q <= 1'b0;
         if (accept_word) words_left <= words_left - 1'b1;
         if (collide) begin
            state      <= ST_JAM;
            cnt        <= '0;
            words_left <= '0;
         end else begin
            case (state)
               ST_IDLE: if (accept_len) begin
                  len_q      <= host_data[LEN_W-1:0];
                  words_left <= words_init;
                  cnt        <= '0;
                  state      <= ST_DEFER;
               end
               ST_DEFER: begin
                  if (carrier)              cnt <= '0;
                  else if (cnt == IFG_LAST) begin
                     cnt   <= '0;
                     state <= ST_PRE;
                  end else                  cnt <= cnt + 1'b1;
               end
               ST_PRE: begin
                  if (cnt == PRE_LAST) begin
                     cnt   <= '0;
                     oct_q <= '0;
                     state <= ST_DATA;
                  end else cnt <= cnt + 1'b1;
               end
               ST_DATA: begin
                  if (in_data) sh_q <= load_now ? (buf_rd >> 1) : (sh_q >> 1);
                  if (cnt == OCT_LAST) begin
                     cnt   <= '0;
                     oct_q <= oct_inc;
                     if (oct_inc == send_octs) state <= ST_FCS;
                  end else cnt <= cnt + 1'b1;
               end
               ST_FCS: begin
                  if (cnt == FCS_LAST) begin
                     cnt     <= '0;
                     tries_q <= '0;
                     state   <= ST_IDLE;
                  end else cnt <= cnt + 1'b1;
               end
               ST_JAM: begin
                  if (cnt == JAM_LAST) begin
                     cnt <= '0;
                     if (last_try) begin
                        abort_q <= 1'b1;
                        tries_q <= '0;
                        state   <= ST_IDLE;
                     end else begin
                        halt_q  <= 1'b1;
                        tries_q <= tries_next;
                        state   <= ST_BACK;
                     end
                  end else cnt <= cnt + 1'b1;
               end
               ST_BACK: if (bo_done) state <= ST_IDLE;
               default: state <= ST_IDLE;
            endcase
         end
      end
   end
endmodule

// File: rtl/csma_tx_chk.sv
module csma_tx_chk #(
   parameter int IFG_BITS = 96,
   parameter int JAM_BITS = 32
)(
   input logic clk,
   input logic rst_n,
   input logic tx_en,
   input logic halt,
   input logic abort,
   input logic host_busy,
   input logic carrier,
   input logic collision
);
   localparam int Q_W = $clog2(IFG_BITS + 1);
   localparam int J_W = $clog2(JAM_BITS + 2);

   logic [Q_W-1:0] quiet;
   logic [J_W-1:0] jam_cnt;
   logic           in_jam;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          quiet <= '0;
      else if (carrier)                    quiet <= '0;
      else if (int'(quiet) < IFG_BITS)     quiet <= quiet + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         in_jam  <= 1'b0;
         jam_cnt <= '0;
      end else if (!tx_en) begin
         in_jam  <= 1'b0;
         jam_cnt <= '0;
      end else if (!in_jam && collision) begin
         in_jam  <= 1'b1;
         jam_cnt <= '0;
      end else if (in_jam) begin
         jam_cnt <= jam_cnt + 1'b1;
      end
   end

   assert_ifg_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tx_en) |-> (int'(quiet) >= IFG_BITS));

   assert_jam_length_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(tx_en) && in_jam) |-> (int'(jam_cnt) == JAM_BITS));

   assert_halt_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
      halt |=> !halt);

   assert_halt_after_jam_R9: assert property (@(posedge clk) disable iff (!rst_n)
      halt |-> ($fell(tx_en) && in_jam));

   assert_abort_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({halt, abort}));

   assert_abort_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
      abort |-> ($fell(tx_en) && in_jam && !host_busy));
endmodule

bind csma_tx csma_tx_chk #(.IFG_BITS(IFG_BITS), .JAM_BITS(JAM_BITS)) u_chk (
   .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .halt(halt), .abort(abort),
   .host_busy(host_busy), .carrier(carrier), .collision(collision)
);

// File: tb/test_csma_tx.sv
module test_csma_tx;
   localparam int IFG = 96, JAM = 32, SLOT = 2, CAP = 10, TRIES = 4, MINO = 60;

   logic        clk = 1'b0, rst_n = 1'b0;
   logic [15:0] host_data = '0;
   logic        host_wr = 1'b0, host_frame = 1'b0, carrier = 1'b0, collision = 1'b0;
   logic        host_busy, halt, abort, tx_data, tx_en;

   int total = 0, bad = 0;
   byte unsigned payload[256];
   bit  exp_bits[4096];
   bit  got_bits[4096];
   int  n_exp, plen;

   always #2 clk = ~clk;

   csma_tx #(.SLOT_BITS(SLOT), .MAX_TRIES(TRIES), .BACKOFF_CAP(CAP)) i_csma_tx (
      .clk(clk), .rst_n(rst_n), .host_data(host_data), .host_wr(host_wr),
      .host_frame(host_frame), .host_busy(host_busy), .halt(halt), .abort(abort),
      .carrier(carrier), .collision(collision), .tx_data(tx_data), .tx_en(tx_en)
   );

   task automatic check(input bit ok, input string req, input string what, input int act, input int expv);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
      end
   endtask

   task automatic push_byte(input byte unsigned b);
      for (int k = 0; k < 8; k++) begin exp_bits[n_exp] = b[k]; n_exp++; end
   endtask

   // expected line bits from R3..R6
   task automatic build_exp();
      logic [31:0] crc;
      int octs;
      byte unsigned b;
      n_exp = 0;
      for (int i = 0; i < 7; i++) push_byte(8'h55);
      push_byte(8'hD5);
      octs = (plen < MINO) ? MINO : plen;
      crc = 32'hFFFFFFFF;
      for (int i = 0; i < octs; i++) begin
         b = (i < plen) ? payload[i] : 8'h00;
         for (int k = 0; k < 8; k++) begin
            if (crc[0] ^ b[k]) crc = (crc >> 1) ^ 32'hEDB88320;
            else               crc = crc >> 1;
         end
         push_byte(b);
      end
      crc = ~crc;
      for (int k = 0; k < 32; k++) begin exp_bits[n_exp] = crc[k]; n_exp++; end
   endtask

   task automatic mism(input int lo, input int hi, output int m);
      m = 0;
      for (int i = lo; i < hi; i++) if (got_bits[i] != exp_bits[i]) m++;
   endtask

   task automatic run_frame(input int n_coll, input int coll_bit, input int carr_cyc,
                            input bit spam, input bit want_abort);
      int  wi = 0, cyc = 0, n_got = 0, attempt = 0, halt_cyc = 0, first_tx = -1, m;
      int  nwords = (plen + 1) / 2;
      int  data_end = 64 + 8 * plen;
      int  pad_end = 64 + 8 * ((plen < MINO) ? MINO : plen);
      bit  len_sent = 0, done = 0, in_tx = 0, wait_bo = 0;
      while (!done && cyc < 40000) begin
         @(negedge clk);
         cyc++;
         host_wr = 1'b0; collision = 1'b0;
         carrier = (cyc <= carr_cyc);
         if (tx_en) begin
            if (first_tx < 0) first_tx = cyc;
            got_bits[n_got] = tx_data; n_got++;
            if (attempt < n_coll && n_got == coll_bit + 1) collision = 1'b1;
         end
         if (halt) begin
            int ones = 0;
            for (int i = coll_bit + 1; i < n_got; i++) ones += got_bits[i];
            mism(0, coll_bit + 1, m);
            check(n_got == coll_bit + 1 + JAM, "R8", "cycles with tx_en", n_got, coll_bit + 1 + JAM);
            check(ones == JAM && m == 0, "R8", "jam ones / prefix errors", ones * 1000 + m, JAM * 1000);
            check(in_tx, "R9", "halt right after jam", 0, 1);
            attempt++; halt_cyc = cyc; wait_bo = 1;
            len_sent = 0; wi = 0; n_got = 0; first_tx = -1;
         end else if (abort) begin
            check(want_abort && attempt + 1 == TRIES, "R11", "abort on collision number", attempt + 1, TRIES);
            check(!host_busy, "R11", "busy in abort cycle", host_busy, 0);
            done = 1;
         end else if (in_tx && !tx_en) begin
            check(!want_abort, "R11", "frame ended without abort", 0, 1);
            check(n_got == n_exp, "R12", "tx_en run length", n_got, n_exp);
            mism(0, 64, m);              check(m == 0, "R3", "preamble bit errors", m, 0);
            mism(64, data_end, m);       check(m == 0, "R4", "content bit errors", m, 0);
            if (plen < MINO) begin
               mism(data_end, pad_end, m); check(m == 0, "R5", "pad bit errors", m, 0);
            end
            mism(pad_end, n_exp, m);     check(m == 0, "R6", "check bit errors", m, 0);
            if (n_coll > 0) check(attempt == n_coll, "R9", "halts before success", attempt, n_coll);
            if (carr_cyc > 0 && n_coll == 0)
               check(first_tx - carr_cyc == IFG + 1, "R7", "gap after carrier", first_tx - carr_cyc, IFG + 1);
            done = 1;
         end
         if (wait_bo && !host_busy && !halt) begin
            int gap = cyc - halt_cyc;
            int lim = 2 ** ((attempt < CAP) ? attempt : CAP);
            check((gap - 1) % SLOT == 0 && (gap - 1) / SLOT < lim, "R10", "backoff length", gap, lim * SLOT);
            wait_bo = 0;
         end
         in_tx = tx_en;
         if (!done && !wait_bo) begin
            if (!host_busy) begin
               if (!len_sent) begin
                  host_wr = 1'b1; host_frame = 1'b0; host_data = 16'(plen); len_sent = 1;
               end else if (wi < nwords) begin
                  host_wr = 1'b1; host_frame = 1'b1;
                  host_data[7:0]  = payload[2*wi];
                  host_data[15:8] = (2*wi + 1 < plen) ? payload[2*wi+1] : 8'($urandom);
                  wi++;
               end
            end else if (spam && len_sent && ($urandom % 3 == 0)) begin
               // R2: writes while busy must change nothing
               host_wr = 1'b1; host_frame = 1'($urandom); host_data = 16'($urandom);
            end
         end
      end
      if (!done) check(0, "R12", "frame never finished", cyc, 0);
      @(negedge clk); host_wr = 1'b0; collision = 1'b0; carrier = 1'b0;
   endtask

   task automatic new_frame(input int len);
      plen = len;
      for (int i = 0; i < len; i++) payload[i] = 8'($urandom);
      build_exp();
   endtask

   initial begin
      #(4 * 190000);
      check(0, "R12", "watchdog expired", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      check(!tx_en && !halt && !abort && !host_busy, "R1", "outputs in reset",
            {tx_en, halt, abort, host_busy}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(!tx_en && !halt && !abort && !host_busy, "R1", "outputs after reset",
            {tx_en, halt, abort, host_busy}, 0);

      new_frame(64);  run_frame(0, 0, 0, 0, 0);               // even length
      new_frame(15);  run_frame(0, 0, 0, 0, 0);               // odd, padded
      new_frame(1);   run_frame(0, 0, 0, 1, 0);               // single octet
      new_frame(20);  run_frame(0, 0, 40, 1, 0);              // R7 carrier hold
      new_frame(70);  run_frame(1, 0, 0, 0, 0);               // collision on first bit
      new_frame(61);  run_frame(2, 200, 0, 1, 0);             // mid-content, twice
      new_frame(33);  run_frame(1, n_exp - 1, 0, 0, 0);       // last check bit vs collision
      new_frame(40);  run_frame(TRIES, 30, 0, 0, 1);          // R11 retry limit
      new_frame(18);  run_frame(0, 0, 0, 0, 0);               // clean after abort
      for (int r = 0; r < 8; r++) begin
         int nc;
         new_frame(1 + int'($urandom % 100));
         nc = int'($urandom % 3);
         run_frame(nc, int'($urandom % n_exp), int'($urandom % 2) * 10, 1'($urandom), 0);
      end
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule